// File: doc/BRIEF.md
# Legacy address range routing decoder

This block sits in the path of processor-initiated memory and I/O transactions and picks a destination for each one. The destination is the default south link, one of two PCI Express ports, or local DRAM that holds the system-management RAM window. Many rules feed the choice. Monochrome-display (MDA) and VGA resources overlap in I/O space. I/O decode works on whole doublewords, and address bits A[15:10] are ignored. The IOAPIC memory range is split across the ports. A lockable enable opens the SMRAM window while the processor is in system-management mode.

Routing is controlled by a small control register with three fields: an MDA-present flag, an IOAPIC-range disable and a global SMRAM enable. Each port supplies a VGA-enable bit, an ISA-enable bit and a precomputed hit on its I/O base/limit window. The decision is registered, so it appears one cycle after the request together with a valid strobe. If software programs the illegal combination of MDA present with no VGA port, a sticky error flag is raised.

Top module: `legacy_route_dec`

## Requirements
- R1: After a synchronous active-low reset the control register reads 00h on `ctl_value`, `rsp_valid` is 0, `cfg_err` is 0 and the internal lock state is clear.
- R2: A request accepted on a clock edge produces `rsp_valid`=1 and its `rsp_target` right after that edge. `rsp_valid` is 0 after any cycle without a request. Target codes are 00 south link, 01 port 0, 10 port 1 and 11 DRAM.
- R3: The control register is 8 bits wide. Bit 0 is the global SMRAM enable, bit 1 is the IOAPIC-range disable and bit 2 is MDA present. A write through `cfg_wr_en` loads `cfg_wr_fields[2:0]` into those bits, and bits 7:3 always read 0.
- R4: Once `lock_in` has been high on any clock edge, later writes leave the SMRAM enable bit unchanged until reset. The other two fields stay writable.
- R5: MDA I/O locations are 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and any byte of the doubleword 3BCh–3BFh. Address bits 15:10 are not decoded, so aliases match too. The 3BCh doubleword is the only MDA-only I/O range.
- R6: VGA resources are I/O 3B0h–3BBh and 3C0h–3DFh, and memory A0000h–BFFFFh. The MDA memory range is B0000h–B7FFFh. With no VGA-enabled port, every MDA or VGA hit goes to the south link.
- R7: With a VGA-enabled port and MDA present clear, VGA hits go to that port (port 0 wins if both are enabled) and MDA-only hits go to the south link.
- R8: With a VGA-enabled port and MDA present set, any access that touches an MDA location goes to the south link, even if it also covers other bytes. The remaining VGA hits go to the VGA port.
- R9: With the IOAPIC disable clear, FEC00000h–FEC7FFFFh goes south, FEC80000h–FEC80FFFh goes to port 0 and FEC81000h–FEC81FFFh goes to port 1. With the disable set, all of FEC00000h–FEC81FFFh goes south.
- R10: A memory access in A0000h–BFFFFh goes to DRAM when the SMRAM enable is set and `req_smm` is 1. Otherwise it follows the legacy rules. Memory outside every named range goes south.
- R11: An I/O access with no legacy hit goes to the lowest-numbered port whose window hit is 1 and whose ISA enable is 0. Otherwise it goes south.
- R12: While MDA present is set and no port has VGA enabled, every request goes south. `cfg_err` becomes 1 on the next edge and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wr_fields | input | 3 | Field values: [0] SMRAM enable, [1] IOAPIC disable, [2] MDA present |
| lock_in | input | 1 | Lock request for the SMRAM enable field |
| req_valid | input | 1 | Transaction present this cycle |
| req_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_addr | input | 32 | Transaction address |
| req_be | input | 4 | Byte enables within the addressed doubleword |
| req_smm | input | 1 | Access made in system-management mode |
| vga_en | input | 2 | Per-port VGA enable |
| isa_en | input | 2 | Per-port ISA enable |
| win_hit | input | 2 | Per-port I/O base/limit window hit |
| rsp_valid | output | 1 | Routing result valid |
| rsp_target | output | 2 | Routing target code |
| cfg_err | output | 1 | Sticky illegal-configuration flag |
| ctl_value | output | 8 | Current control register contents |

## Verification
The assertions assume that `vga_en` and the control fields stay stable during a request. This holds because the bench changes them only in idle cycles, between requests. They also assume that an I/O request carries at least one byte enable, and every I/O request in the directed tests does. The target properties compare one cycle of request inputs against the next cycle's output. Every request is therefore held for exactly one edge and then dropped, so each result lines up with a single request.

// File: rtl/lrd_pkg.sv
// Shared types and constants for the legacy routing decoder.
// Assumes exactly two downstream ports, matching the 2-bit target code.
package lrd_pkg;
    localparam int NUM_PORTS    = 2;
    localparam int CTL_W        = 8;
    localparam int CTL_SMRAM_B  = 0;
    localparam int CTL_APIC_B   = 1;
    localparam int CTL_MDA_B    = 2;
    localparam int FIELD_W      = CTL_MDA_B + 1;

    typedef enum logic [1:0] {
        TGT_SOUTH = 2'b00,
        TGT_PORT0 = 2'b01,
        TGT_PORT1 = 2'b10,
        TGT_DRAM  = 2'b11
    } tgt_e;

    // Legacy display resource hits for one access
    typedef struct packed {
        logic mda_any;   // touches any MDA resource
        logic mda_only;  // touches an MDA-only resource
        logic vga;       // touches a VGA resource
    } leg_hit_t;
endpackage

// File: rtl/lrd_ctl_reg.sv
// Control register with lockable SMRAM enable and sticky illegal-mode flag.
// Assumes lock_in is synchronous to clk; the lock is held until reset.
module lrd_ctl_reg
    import lrd_pkg::*;
#(
    parameter int PORTS = NUM_PORTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_fields,
    input  logic               lock_in,
    input  logic [PORTS-1:0]   vga_en,
    output logic               smram_en,
    output logic               apic_off,
    output logic               mda_on,
    output logic               lock_hold,
    output logic               illegal,
    output logic               err_sticky
);
    // Illegal when MDA is claimed present but no port decodes VGA
    always_comb illegal = mda_on && !(|vga_en);

    // Field storage, lock capture and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smram_en   <= 1'b0;
            apic_off   <= 1'b0;
            mda_on     <= 1'b0;
            lock_hold  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            if (wr_en) begin
                apic_off <= wr_fields[CTL_APIC_B];
                mda_on   <= wr_fields[CTL_MDA_B];
                if (!(lock_hold || lock_in))
                    smram_en <= wr_fields[CTL_SMRAM_B];
            end
            lock_hold  <= lock_hold | lock_in;
            err_sticky <= err_sticky | illegal;
        end
    end
endmodule

// File: rtl/lrd_io_decode.sv
// Legacy I/O resource decoder on doubleword granularity.
// Only address bits 9:0 are decoded, so all A[15:10] aliases match.
module lrd_io_decode
    import lrd_pkg::*;
#(
    parameter int DEC_BITS = 10
) (
    input  logic [DEC_BITS-1:0] addr,
    input  logic [3:0]          be,
    output leg_hit_t            hit
);
    localparam int DW_W = DEC_BITS - 2;
    localparam logic [DW_W-1:0] DW_3B0 = DW_W'(10'h3B0 >> 2);
    localparam logic [DW_W-1:0] DW_3B4 = DW_W'(10'h3B4 >> 2);
    localparam logic [DW_W-1:0] DW_3B8 = DW_W'(10'h3B8 >> 2);
    localparam logic [DW_W-1:0] DW_3BC = DW_W'(10'h3BC >> 2);
    localparam logic [DW_W-1:0] DW_3C0 = DW_W'(10'h3C0 >> 2);
    localparam logic [DW_W-1:0] DW_3DC = DW_W'(10'h3DC >> 2);

    logic [DW_W-1:0] dw;
    logic            any_b;

    // Per-doubleword match of MDA and VGA resources
    always_comb begin
        dw           = addr[DEC_BITS-1:2];
        any_b        = |be;
        hit.mda_only = any_b && (dw == DW_3BC);
        hit.mda_any  = hit.mda_only
                     || ((dw == DW_3B4) && (be[0] || be[1]))
                     || ((dw == DW_3B8) && (|be[2:0]));
        hit.vga      = any_b && (((dw >= DW_3B0) && (dw <= DW_3B8))
                     || ((dw >= DW_3C0) && (dw <= DW_3DC)));
    end
endmodule

// File: rtl/lrd_mem_decode.sv
// Legacy memory range decoder: display windows, SMRAM window, IOAPIC split.
// Assumes a flat physical address of ADDR_W bits.
module lrd_mem_decode
    import lrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output leg_hit_t          hit,
    output logic              smram_win,
    output logic              apic_any,
    output logic              apic_p0,
    output logic              apic_p1
);
    localparam logic [ADDR_W-1:0] VGA_LO  = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] VGA_HI  = ADDR_W'(32'h000B_FFFF);
    localparam logic [ADDR_W-1:0] MDA_LO  = ADDR_W'(32'h000B_0000);
    localparam logic [ADDR_W-1:0] MDA_HI  = ADDR_W'(32'h000B_7FFF);
    localparam logic [ADDR_W-1:0] APIC_LO = ADDR_W'(32'hFEC0_0000);
    localparam logic [ADDR_W-1:0] P0_LO   = ADDR_W'(32'hFEC8_0000);
    localparam logic [ADDR_W-1:0] P1_LO   = ADDR_W'(32'hFEC8_1000);
    localparam logic [ADDR_W-1:0] P1_HI   = ADDR_W'(32'hFEC8_1FFF);

    // Range compares for each legacy memory resource
    always_comb begin
        hit.vga      = (addr >= VGA_LO) && (addr <= VGA_HI);
        hit.mda_any  = (addr >= MDA_LO) && (addr <= MDA_HI);
        hit.mda_only = 1'b0;
        smram_win    = hit.vga;
        apic_any     = (addr >= APIC_LO) && (addr <= P1_HI);
        apic_p0      = (addr >= P0_LO) && (addr < P1_LO);
        apic_p1      = (addr >= P1_LO) && (addr <= P1_HI);
    end
endmodule

// File: rtl/legacy_route_dec.sv
// Top of the legacy routing decoder: combines register state and the range
// decoders into one target per request, registered with a valid strobe.
// Assumes control fields and vga_en are stable while a request is presented.
module legacy_route_dec
    import lrd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DEC_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [FIELD_W-1:0]   cfg_wr_fields,
    input  logic                 lock_in,
    input  logic                 req_valid,
    input  logic                 req_is_io,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_be,
    input  logic                 req_smm,
    input  logic [NUM_PORTS-1:0] vga_en,
    input  logic [NUM_PORTS-1:0] isa_en,
    input  logic [NUM_PORTS-1:0] win_hit,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_target,
    output logic                 cfg_err,
    output logic [CTL_W-1:0]     ctl_value
);
    logic     ctl_smram, ctl_apic_off, ctl_mda_on, lock_hold, cfg_illegal;
    leg_hit_t io_hit, mem_hit, leg;
    logic     smram_win, apic_any, apic_p0, apic_p1;
    tgt_e     vga_port, win_port, next_tgt;
    logic     win_found;

    lrd_ctl_reg #(.PORTS(NUM_PORTS)) ctl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_fields(cfg_wr_fields),
        .lock_in(lock_in), .vga_en(vga_en), .smram_en(ctl_smram),
        .apic_off(ctl_apic_off), .mda_on(ctl_mda_on), .lock_hold(lock_hold),
        .illegal(cfg_illegal), .err_sticky(cfg_err)
    );

    lrd_io_decode #(.DEC_BITS(DEC_BITS)) io_i (
        .addr(req_addr[DEC_BITS-1:0]), .be(req_be), .hit(io_hit)
    );

    lrd_mem_decode #(.ADDR_W(ADDR_W)) mem_i (
        .addr(req_addr), .hit(mem_hit), .smram_win(smram_win),
        .apic_any(apic_any), .apic_p0(apic_p0), .apic_p1(apic_p1)
    );

    // Register image: three fields, reserved bits read zero
    always_comb begin
        ctl_value              = '0;
        ctl_value[CTL_SMRAM_B] = ctl_smram;
        ctl_value[CTL_APIC_B]  = ctl_apic_off;
        ctl_value[CTL_MDA_B]   = ctl_mda_on;
    end

    // Lowest-numbered port for VGA and for base/limit windows
    always_comb begin
        vga_port  = TGT_PORT0;
        win_port  = TGT_SOUTH;
        win_found = 1'b0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (vga_en[p]) vga_port = tgt_e'(2'(p + 1));
            if (win_hit[p] && !isa_en[p]) begin
                win_port  = tgt_e'(2'(p + 1));
                win_found = 1'b1;
            end
        end
    end

    // Routing priority: illegal mode, SMRAM, legacy display, windows, IOAPIC
    always_comb begin
        leg      = req_is_io ? io_hit : mem_hit;
        next_tgt = TGT_SOUTH;
        if (cfg_illegal) begin
            next_tgt = TGT_SOUTH;
        end else if (!req_is_io && smram_win && ctl_smram && req_smm) begin
            next_tgt = TGT_DRAM;
        end else if (leg.vga || leg.mda_any) begin
            if ((|vga_en) && leg.vga
                && !(ctl_mda_on ? leg.mda_any : leg.mda_only))
                next_tgt = vga_port;
        end else if (req_is_io) begin
            if (win_found) next_tgt = win_port;
        end else if (apic_any && !ctl_apic_off) begin
            if (apic_p0)      next_tgt = TGT_PORT0;
            else if (apic_p1) next_tgt = TGT_PORT1;
        end
    end

    // Output stage: one cycle of latency with valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_target <= TGT_SOUTH;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_target <= next_tgt;
        end
    end
endmodule

// File: rtl/legacy_route_dec_chk.sv
// Property checker bound to the routing decoder top.
module legacy_route_dec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_is_io,
    input logic       req_smm,
    input logic [1:0] vga_en,
    input logic       rsp_valid,
    input logic [1:0] rsp_target,
    input logic       cfg_err,
    input logic       lock_in,
    input logic       lock_hold,
    input logic       ctl_smram,
    input logic       ctl_mda_on
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_in || lock_hold) |=> $stable(ctl_smram));
    a_r10_dram_needs_smm: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_is_io || !req_smm)) |=> rsp_target != 2'b11);
    a_r12_illegal_south: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_mda_on && vga_en == 2'b00) |=> rsp_target == 2'b00);
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind legacy_route_dec legacy_route_dec_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_smm(req_smm), .vga_en(vga_en), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .cfg_err(cfg_err), .lock_in(lock_in),
    .lock_hold(lock_hold), .ctl_smram(ctl_smram), .ctl_mda_on(ctl_mda_on)
);

// File: tb/legacy_route_dec_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module legacy_route_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_fields = '0;
    logic        lock_in = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        req_smm = 1'b0;
    logic [1:0]  vga_en = '0;
    logic [1:0]  isa_en = '0;
    logic [1:0]  win_hit = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic        cfg_err;
    logic [7:0]  ctl_value;
    int          n_checks = 0;
    int          n_errors = 0;

    legacy_route_dec dut_i (.*);

    always #4 clk = ~clk;

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(logic [2:0] f);
        @(negedge clk);
        cfg_wr_fields = f;
        cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Issue one request, check the target one edge later
    task automatic route(string req, logic io, logic [31:0] a, logic [3:0] be,
                         logic smm, logic [1:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_is_io = io; req_addr = a; req_be = be; req_smm = smm;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, int'(rsp_valid), 1);
        check(req, int'(rsp_target), int'(exp));
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 ctl", int'(ctl_value), 0);
        check("R1 valid", int'(rsp_valid), 0);
        check("R1 err", int'(cfg_err), 0);
        @(negedge clk);
        check("R2 idle", int'(rsp_valid), 0);
    endtask

    task automatic t_register();
        write_cfg(3'b111);
        vga_en = 2'b01;
        check("R3 fields", int'(ctl_value), 8'h07);
        write_cfg(3'b010);
        check("R3 apic only", int'(ctl_value), 8'h02);
        write_cfg(3'b000);
        vga_en = 2'b00;
    endtask

    task automatic t_apic();
        route("R9 low", 0, 32'hFEC0_0010, 4'hF, 0, 2'b00);
        route("R9 p0", 0, 32'hFEC8_0004, 4'hF, 0, 2'b01);
        route("R9 p1", 0, 32'hFEC8_1FFC, 4'hF, 0, 2'b10);
        route("R10 beyond", 0, 32'hFEC8_2000, 4'hF, 0, 2'b00);
        write_cfg(3'b010);
        route("R9 off p0", 0, 32'hFEC8_0004, 4'hF, 0, 2'b00);
        route("R9 off p1", 0, 32'hFEC8_1000, 4'hF, 0, 2'b00);
        write_cfg(3'b000);
    endtask

    task automatic t_smram();
        route("R10 closed", 0, 32'h000A_0000, 4'hF, 1, 2'b00);
        write_cfg(3'b001);
        route("R10 open lo", 0, 32'h000A_0000, 4'hF, 1, 2'b11);
        route("R10 open hi", 0, 32'h000B_FFFC, 4'hF, 1, 2'b11);
        route("R10 outside", 0, 32'h000C_0000, 4'hF, 1, 2'b00);
        route("R10 no smm", 0, 32'h000A_0000, 4'hF, 0, 2'b00);
    endtask

    task automatic t_lock();
        @(negedge clk); lock_in = 1'b1;
        @(negedge clk); lock_in = 1'b0;
        write_cfg(3'b010);
        check("R4 smram kept", int'(ctl_value), 8'h03);
        route("R4 still dram", 0, 32'h000A_0000, 4'hF, 1, 2'b11);
        route("R4 apic writable", 0, 32'hFEC8_0000, 4'hF, 0, 2'b00);
        do_reset();
        check("R1 lock cleared ctl", int'(ctl_value), 0);
        write_cfg(3'b001);
        check("R4 unlocked after reset", int'(ctl_value), 8'h01);
        write_cfg(3'b000);
    endtask

    task automatic t_io_novga();
        vga_en = 2'b00; win_hit = 2'b01; isa_en = 2'b00;
        route("R6 mda dw", 1, 32'h0000_03BC, 4'b1000, 0, 2'b00);
        route("R6 vga io", 1, 32'h0000_03C0, 4'b0001, 0, 2'b00);
        route("R6 vga mem", 0, 32'h000B_8000, 4'hF, 0, 2'b00);
        route("R11 win p0", 1, 32'h0000_0300, 4'b0001, 0, 2'b01);
        win_hit = 2'b10;
        route("R11 win p1", 1, 32'h0000_0300, 4'b0001, 0, 2'b10);
        win_hit = 2'b11; isa_en = 2'b01;
        route("R11 isa skip", 1, 32'h0000_0300, 4'b0001, 0, 2'b10);
        isa_en = 2'b11;
        route("R11 isa all", 1, 32'h0000_0300, 4'b0001, 0, 2'b00);
        win_hit = 2'b00; isa_en = 2'b00;
    endtask

    task automatic t_io_vga_nomda();
        vga_en = 2'b10;
        route("R7 vga 3C4", 1, 32'h0000_03C4, 4'b0001, 0, 2'b10);
        route("R7 3B4 is vga", 1, 32'h0000_03B4, 4'b0001, 0, 2'b10);
        route("R5 alias 7BC", 1, 32'h0000_07BC, 4'b0001, 0, 2'b00);
        route("R7 vga 3B0", 1, 32'h0000_03B0, 4'b0010, 0, 2'b10);
        route("R7 mem mda", 0, 32'h000B_0000, 4'hF, 0, 2'b10);
        vga_en = 2'b11;
        route("R7 port0 wins", 1, 32'h0000_03DC, 4'b1000, 0, 2'b01);
    endtask

    task automatic t_io_vga_mda();
        vga_en = 2'b01;
        write_cfg(3'b100);
        route("R8 3B4", 1, 32'h0000_03B4, 4'b0001, 0, 2'b00);
        route("R8 3B6", 1, 32'h0000_03B4, 4'b0100, 0, 2'b01);
        route("R8 3BB", 1, 32'h0000_03B8, 4'b1000, 0, 2'b01);
        route("R8 mixed dw", 1, 32'h0000_03B8, 4'b1111, 0, 2'b00);
        route("R5 alias FBB8", 1, 32'h0000_FBB8, 4'b0001, 0, 2'b00);
        route("R8 mem mda", 0, 32'h000B_0000, 4'hF, 0, 2'b00);
        route("R8 mem vga", 0, 32'h000B_8000, 4'hF, 0, 2'b01);
        route("R8 mem A0000", 0, 32'h000A_0000, 4'hF, 0, 2'b01);
        write_cfg(3'b000);
    endtask

    task automatic t_illegal();
        vga_en = 2'b00;
        check("R12 err before", int'(cfg_err), 0);
        write_cfg(3'b100);
        @(negedge clk);
        check("R12 err set", int'(cfg_err), 1);
        route("R12 apic south", 0, 32'hFEC8_0000, 4'hF, 0, 2'b00);
        win_hit = 2'b01;
        route("R12 window south", 1, 32'h0000_0300, 4'b0001, 0, 2'b00);
        win_hit = 2'b00;
        vga_en = 2'b01;
        write_cfg(3'b000);
        @(negedge clk);
        check("R12 err sticky", int'(cfg_err), 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_register();
        t_apic();
        t_smram();
        t_lock();
        t_io_novga();
        t_io_vga_nomda();
        t_io_vga_mda();
        t_illegal();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule